// File: doc/BRIEF.md
# Trilinear Voxel Plane Interpolator

This block turns the eight voxels that surround one sample point into a single interpolated sample. Each voxel carries an 8-bit opacity and an 8-bit colour. All eight arrive together in one load, with three 8-bit fractional weights that place the sample point inside the cell, and a valid flag.

The design reuses one plane (bilinear) interpolator, instantiated for the near and the far plane of the cell. Each plane instance first blends along X on the two edges of its plane, then along Y. A final stage blends the two plane results along Z, which gives full trilinear interpolation. Opacity and colour travel side by side through the same stages with the same weights. The pipeline is fixed, accepts one load per cycle and delivers each result four cycles after it was accepted. It sits between a voxel cache and a compositing stage.

Top module: `voxel_trilerp`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `valid_out` is low and both `opa_out` and `col_out` are 0.
- R2: A load accepted with `valid_in` high at a clock edge shows up with `valid_out` high exactly 4 rising edges later. Loads on consecutive cycles give results on consecutive cycles, in the same order. Every result matches exactly one load.
- R3: Every linear blend is computed as lerp(a, b, f) = a + trunc((b - a) * f / 256), where trunc rounds toward zero and f is an unsigned weight in 0..255. The result is clamped to 0..255. The order is: X on the four cell edges, then Y within each plane, then Z between the planes.
- R4: Voxel i sits at bits [8i+7:8i] of `opa_in` and `col_in`, with i = x + 2*y + 4*z. Weight `frac_x` moves from x=0 to x=1, `frac_y` from y=0 to y=1, and `frac_z` from z=0 to z=1.
- R5: Opacity and colour are interpolated independently, each with the same three weights. Neither channel affects the other.
- R6: When all three weights are 0, both outputs equal voxel 0 exactly.
- R7: When all three weights are 255, each output lies within 3 LSB of voxel 7. Each of the three stages may fall at most 1 LSB short.
- R8: While `valid_out` is low, `opa_out` and `col_out` keep the value of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | The load on the data inputs is taken this cycle |
| opa_in | input | 64 | Eight voxel opacities, voxel i at [8i+7:8i] |
| col_in | input | 64 | Eight voxel colours, voxel i at [8i+7:8i] |
| frac_x | input | 8 | X weight, value/256 |
| frac_y | input | 8 | Y weight, value/256 |
| frac_z | input | 8 | Z weight, value/256 |
| valid_out | output | 1 | The outputs hold a new result this cycle |
| opa_out | output | 8 | Interpolated opacity |
| col_out | output | 8 | Interpolated colour |

## Verification
The bench applies single-axis weights that move only one voxel, so that a swapped voxel index or a swapped axis gives an exact miscompare. It uses voxels at 0 and 255 with weights near the top of their range. A shift that floors negative products instead of truncating them toward zero is then off by one on every falling edge of the cell. A missing clamp wraps there. Opacity and colour get different data, so crossed channels are caught. Back-to-back loads with gaps between them show a wrong pipeline depth, a weight that is not delayed in step with its data (the result blends with the weight of another load), and outputs that change while `valid_out` is low.

// File: rtl/voxel_trilerp_pkg.sv
// Shared widths, the voxel sample type and the single linear blend used by
// every interpolation stage. Assumes weights are unsigned fractions of 2**FRAC_W.
package voxel_trilerp_pkg;
    localparam int DATA_W = 8;
    localparam int FRAC_W = 8;
    localparam int NUM_VOX = 8;
    localparam int PROD_W = DATA_W + FRAC_W + 3;

    typedef struct packed {
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] col;
    } sample_t;

    // a + trunc((b-a)*f / 2**FRAC_W), truncation toward zero, clamped to range.
    function automatic logic [DATA_W-1:0] blend1(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic [FRAC_W-1:0] f);
        logic signed [DATA_W+1:0] diff;
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] step;
        logic signed [PROD_W-1:0] sum;
        diff = $signed({2'b00, b}) - $signed({2'b00, a});
        prod = PROD_W'(diff * $signed({1'b0, f}));
        if (prod < 0)
            prod = prod + $signed({{(DATA_W+3){1'b0}}, {FRAC_W{1'b1}}});
        step = prod >>> FRAC_W;
        sum = $signed({{(FRAC_W+3){1'b0}}, a}) + step;
        if (sum < 0)
            return '0;
        else if (sum > $signed({{(FRAC_W+3){1'b0}}, {DATA_W{1'b1}}}))
            return '1;
        else
            return sum[DATA_W-1:0];
    endfunction

    // Applies blend1 to both channels with one weight.
    function automatic sample_t blend2(input sample_t a, input sample_t b,
                                       input logic [FRAC_W-1:0] f);
        sample_t r;
        r.opa = blend1(a.opa, b.opa, f);
        r.col = blend1(a.col, b.col, f);
        return r;
    endfunction
endpackage

// File: rtl/voxel_plane_lerp.sv
// Bilinear interpolator for one plane of the cell: X on both edges, then Y.
// Two register stages; the Y weight is delayed one stage to meet its edges.
// Assumes corners are indexed c[x + 2*y].
module voxel_plane_lerp
    import voxel_trilerp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  sample_t           c00,
    input  sample_t           c10,
    input  sample_t           c01,
    input  sample_t           c11,
    input  logic [FRAC_W-1:0] fx,
    input  logic [FRAC_W-1:0] fy,
    output logic              valid_out,
    output sample_t           plane
);
    sample_t           edge0_q, edge1_q;
    logic [FRAC_W-1:0] fy_q;
    logic              valid_a;

    // Stage A: blend along X on the y=0 and y=1 edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_a <= 1'b0;
            edge0_q <= '0;
            edge1_q <= '0;
            fy_q    <= '0;
        end else begin
            valid_a <= valid_in;
            edge0_q <= blend2(c00, c10, fx);
            edge1_q <= blend2(c01, c11, fx);
            fy_q    <= fy;
        end
    end

    // Stage B: blend the two edges along Y.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            plane     <= '0;
        end else begin
            valid_out <= valid_a;
            plane     <= blend2(edge0_q, edge1_q, fy_q);
        end
    end

    // R3: a bilinear result never leaves the range of its four corners.
    assert_plane_in_hull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |->
            (plane.opa >= $past(c00.opa, 2) || plane.opa >= $past(c10.opa, 2) ||
             plane.opa >= $past(c01.opa, 2) || plane.opa >= $past(c11.opa, 2)) &&
            (plane.opa <= $past(c00.opa, 2) || plane.opa <= $past(c10.opa, 2) ||
             plane.opa <= $past(c01.opa, 2) || plane.opa <= $past(c11.opa, 2)));

    // R6: zero weights pass corner 00 through unchanged.
    assert_plane_zero_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && $past(fx, 2) == '0 && $past(fy, 2) == '0) |->
            plane == $past(c00, 2));
endmodule

// File: rtl/voxel_z_blend.sv
// Blends the near and far plane results along Z, then registers the result
// on the block outputs. The output register loads only with valid data, so
// it holds between results. Assumes fz arrives aligned with the planes.
module voxel_z_blend
    import voxel_trilerp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  sample_t           near_pl,
    input  sample_t           far_pl,
    input  logic [FRAC_W-1:0] fz,
    output logic              valid_out,
    output sample_t           result
);
    sample_t z_q;
    logic    valid_c;

    // Stage C: blend along Z.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_c <= 1'b0;
            z_q     <= '0;
        end else begin
            valid_c <= valid_in;
            z_q     <= blend2(near_pl, far_pl, fz);
        end
    end

    // Stage D: output register, loaded only for a valid result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            result    <= '0;
        end else begin
            valid_out <= valid_c;
            if (valid_c)
                result <= z_q;
        end
    end

    // R3: the Z blend lies between its two plane inputs (colour channel).
    assert_z_in_hull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_c |->
            ((z_q.col >= $past(near_pl.col) && z_q.col <= $past(far_pl.col)) ||
             (z_q.col <= $past(near_pl.col) && z_q.col >= $past(far_pl.col))));

    // R6: zero Z weight returns the near plane exactly.
    assert_z_zero_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_c && $past(fz) == '0) |-> z_q == $past(near_pl));

    // R8: outputs hold whenever no valid result is loaded.
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_c |=> $stable(result));
endmodule

// File: rtl/voxel_trilerp.sv
// Trilinear interpolator top: unpacks the eight voxels, runs one plane
// interpolator per Z plane (generate), delays the Z weight to match, and
// blends the planes. Fixed latency of four cycles, one load per cycle.
module voxel_trilerp
    import voxel_trilerp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_in,
    input  logic [NUM_VOX*DATA_W-1:0] opa_in,
    input  logic [NUM_VOX*DATA_W-1:0] col_in,
    input  logic [FRAC_W-1:0]         frac_x,
    input  logic [FRAC_W-1:0]         frac_y,
    input  logic [FRAC_W-1:0]         frac_z,
    output logic                      valid_out,
    output logic [DATA_W-1:0]         opa_out,
    output logic [DATA_W-1:0]         col_out
);
    localparam int NUM_PLANES = 2;
    localparam int PLANE_VOX  = NUM_VOX / NUM_PLANES;
    localparam int Z_DELAY    = 2;

    sample_t           vox [NUM_VOX];
    sample_t           plane_res [NUM_PLANES];
    logic              plane_vld [NUM_PLANES];
    logic [FRAC_W-1:0] fz_pipe [Z_DELAY];
    sample_t           result;

    // Unpack voxel i = x + 2y + 4z from the flat input buses.
    for (genvar i = 0; i < NUM_VOX; i++) begin : g_unpack
        assign vox[i].opa = opa_in[i*DATA_W +: DATA_W];
        assign vox[i].col = col_in[i*DATA_W +: DATA_W];
    end

    // One reused bilinear interpolator per plane of the cell.
    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        voxel_plane_lerp u_plane (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid_in  (valid_in),
            .c00       (vox[p*PLANE_VOX + 0]),
            .c10       (vox[p*PLANE_VOX + 1]),
            .c01       (vox[p*PLANE_VOX + 2]),
            .c11       (vox[p*PLANE_VOX + 3]),
            .fx        (frac_x),
            .fy        (frac_y),
            .valid_out (plane_vld[p]),
            .plane     (plane_res[p])
        );
    end

    // Delay the Z weight by the depth of the plane interpolators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < Z_DELAY; k++) fz_pipe[k] <= '0;
        end else begin
            fz_pipe[0] <= frac_z;
            for (int k = 1; k < Z_DELAY; k++) fz_pipe[k] <= fz_pipe[k-1];
        end
    end

    voxel_z_blend u_zblend (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (plane_vld[0]),
        .near_pl   (plane_res[0]),
        .far_pl    (plane_res[1]),
        .fz        (fz_pipe[Z_DELAY-1]),
        .valid_out (valid_out),
        .result    (result)
    );

    assign opa_out = result.opa;
    assign col_out = result.col;

    // R2: each valid result traces back to a load four edges earlier.
    assert_latency_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> $past(valid_in, 4));

    // R2: the two plane instances stay in lockstep.
    assert_planes_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        plane_vld[0] == plane_vld[1]);
endmodule

// File: tb/voxel_trilerp_bench.sv
// Scoreboard bench: the driver computes expected results and queues them,
// the monitor compares on every negative edge.
module voxel_trilerp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [63:0] opa_in = '0;
    logic [63:0] col_in = '0;
    logic [7:0]  frac_x = '0, frac_y = '0, frac_z = '0;
    logic        valid_out;
    logic [7:0]  opa_out, col_out;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    bit    have_last = 0;
    int    last_opa, last_col;
    int    q_opa[$], q_col[$], q_stamp[$], q_ref7o[$], q_ref7c[$];
    string q_tag[$];

    voxel_trilerp u_voxel_trilerp (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .opa_in(opa_in), .col_in(col_in),
        .frac_x(frac_x), .frac_y(frac_y), .frac_z(frac_z),
        .valid_out(valid_out), .opa_out(opa_out), .col_out(col_out)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference blend: integer division truncates toward zero.
    function automatic int lin(int a, int b, int f);
        int r;
        r = a + ((b - a) * f) / 256;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    function automatic int tri3(int v[8], int fx, int fy, int fz);
        int p0, p1;
        p0 = lin(lin(v[0], v[1], fx), lin(v[2], v[3], fx), fy);
        p1 = lin(lin(v[4], v[5], fx), lin(v[6], v[7], fx), fy);
        return lin(p0, p1, fz);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: present one load and queue its expected result.
    task automatic send(int o[8], int c[8], int fx, int fy, int fz, string tag);
        @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) begin
            opa_in[i*8 +: 8] = o[i][7:0];
            col_in[i*8 +: 8] = c[i][7:0];
        end
        frac_x = fx[7:0]; frac_y = fy[7:0]; frac_z = fz[7:0];
        valid_in = 1'b1;
        q_opa.push_back(tri3(o, fx, fy, fz));
        q_col.push_back(tri3(c, fx, fy, fz));
        q_stamp.push_back(cyc);
        q_tag.push_back(tag);
        q_ref7o.push_back((fx == 255 && fy == 255 && fz == 255) ? o[7] : -1);
        q_ref7c.push_back((fx == 255 && fy == 255 && fz == 255) ? c[7] : -1);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            valid_in = 1'b0;
            frac_x = 8'd77; frac_y = 8'd200; frac_z = 8'd13;
            opa_in = {8{8'hA5}}; col_in = {8{8'h3C}};
        end
    endtask

    // Monitor: compare results, latency and idle hold.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_out) begin
                if (q_opa.size() == 0) begin
                    check(0, "R2 unexpected result", 1, 0);
                end else begin
                    int eo, ec, st, r7o, r7c;
                    string tg;
                    eo = q_opa.pop_front(); ec = q_col.pop_front();
                    st = q_stamp.pop_front(); tg = q_tag.pop_front();
                    r7o = q_ref7o.pop_front(); r7c = q_ref7c.pop_front();
                    check(int'(opa_out) == eo, {tg, " opacity"}, int'(opa_out), eo);
                    check(int'(col_out) == ec, {tg, " colour"}, int'(col_out), ec);
                    check(cyc - st == 4, "R2 latency", cyc - st, 4);
                    if (r7o >= 0) begin
                        check(int'(opa_out) <= r7o + 3 && int'(opa_out) + 3 >= r7o,
                              "R7 opacity near voxel 7", int'(opa_out), r7o);
                        check(int'(col_out) <= r7c + 3 && int'(col_out) + 3 >= r7c,
                              "R7 colour near voxel 7", int'(col_out), r7c);
                    end
                end
                last_opa = int'(opa_out);
                last_col = int'(col_out);
                have_last = 1;
            end else if (have_last) begin
                check(int'(opa_out) == last_opa, "R8 opacity hold", int'(opa_out), last_opa);
                check(int'(col_out) == last_col, "R8 colour hold", int'(col_out), last_col);
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int o[8], c[8];
        // R1: reset state, during and just after reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(valid_out == 1'b0, "R1 valid during reset", int'(valid_out), 0);
        check(opa_out == 8'd0 && col_out == 8'd0, "R1 data during reset",
              int'(opa_out) + int'(col_out), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(valid_out == 1'b0, "R1 valid after reset", int'(valid_out), 0);
        check(opa_out == 8'd0 && col_out == 8'd0, "R1 data after reset",
              int'(opa_out) + int'(col_out), 0);

        // R6: zero weights return voxel 0.
        o = '{91, 200, 3, 17, 250, 8, 140, 66};
        c = '{12, 0, 255, 30, 99, 180, 7, 222};
        send(o, c, 0, 0, 0, "R6 zero weights");
        // R7: maximum weights land near voxel 7.
        send(o, c, 255, 255, 255, "R7 max weights");
        o = '{255, 0, 0, 0, 255, 0, 0, 0};
        c = '{0, 255, 255, 255, 0, 255, 255, 255};
        send(o, c, 255, 255, 255, "R7 extreme max");
        idle(3);

        // R4: each axis alone, moving only the matching voxel.
        for (int i = 0; i < 8; i++) begin
            int oo[8], cc[8];
            for (int k = 0; k < 8; k++) begin oo[k] = 40; cc[k] = 200; end
            oo[i] = 240; cc[i] = 10;
            send(oo, cc, (i & 1) ? 192 : 64, (i & 2) ? 160 : 32,
                 (i & 4) ? 224 : 16, "R4 voxel index");
        end
        idle(2);

        // R3: falling and rising edges, truncation toward zero, weights 1 and 255.
        o = '{255, 0, 255, 0, 255, 0, 255, 0};
        c = '{0, 255, 0, 255, 0, 255, 0, 255};
        send(o, c, 1, 0, 0, "R3 small weight");
        send(o, c, 255, 0, 0, "R3 large weight");
        send(o, c, 129, 3, 250, "R3 mixed");
        o = '{10, 11, 9, 12, 200, 201, 199, 198};
        send(o, c, 77, 181, 254, "R3 near-equal corners");
        idle(1);

        // R5: channels independent, one constant while other varies.
        o = '{5, 250, 60, 190, 33, 120, 210, 1};
        for (int k = 0; k < 8; k++) c[k] = 123;
        send(o, c, 100, 150, 200, "R5 channel independence");
        idle(4);

        // R2: long back-to-back stream with random data, then gaps.
        for (int n = 0; n < 60; n++) begin
            for (int k = 0; k < 8; k++) begin
                o[k] = int'($urandom_range(255));
                c[k] = int'($urandom_range(255));
            end
            send(o, c, int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), "R2 stream");
            if (n % 13 == 12) idle(int'($urandom_range(3)) + 1);
        end
        idle(10);
        check(q_opa.size() == 0, "R2 all results delivered", q_opa.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule